// File: doc/BRIEF.md
# Paged program counter unit

This unit holds the 13-bit program counter of a small microcontroller core and works out its next value each cycle. It receives single-cycle control strobes from the instruction decoder: sequential increment, a write of the low address byte with an ALU result, a direct jump or subroutine call carrying an 11-bit target, a return carrying the 13-bit address popped from the return stack, and an interrupt entry. The return stack, decoder and program memory all sit outside the unit.

The upper five counter bits are never written directly. A separate 5-bit page register, written through its own 8-bit port, supplies them. A low-byte write takes all five page bits. A jump takes only the top two page bits and fills the other eleven bits from the opcode target. An offset added to the low byte therefore stays inside the current 256-word block and never carries into the upper bits.

The reset input is asynchronous and active low. It clears the counter and the page register at once. Its release is synchronised to the clock inside the unit.

Top module: `pc_pager`

## Requirements
- R1: While rst_n is low, pc_o, pc_low_rd and page_rd read 0. After rst_n rises, strobes have no effect at the first two rising clock edges. They take effect from the third edge on.
- R2: When inc_en is the only active load strobe, pc_o becomes (pc_o + 1) mod 8192, so 13'h1FFF wraps to 0.
- R3: When low_wr_en is the highest active load strobe, pc_o becomes {page[4:0], low_wr_data}. A computed offset written back to the low byte therefore wraps inside the current 256-word block.
- R4: When jump_en is the highest active load strobe, pc_o becomes {page[4:3], jump_target[10:0]}.
- R5: When ret_en is the highest active load strobe, pc_o becomes ret_addr.
- R6: When irq_vec_en is asserted, pc_o becomes 13'h004.
- R7: The strobes rank irq_vec_en above ret_en, ret_en above jump_en, jump_en above low_wr_en and low_wr_en above inc_en. When no strobe is active, pc_o holds its value.
- R8: A page_wr_en write stores page_wr_data[4:0]. page_rd then reads {3'b000, page}. The new page is visible one cycle after the write, and any load in the same cycle uses the old page.
- R9: The page register changes only on page_wr_en or reset. Return, interrupt, jump, increment and low-byte loads leave it unchanged.
- R10: pc_low_rd always equals pc_o[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_en | input | 1 | Sequential increment strobe |
| low_wr_en | input | 1 | Low-byte write strobe |
| low_wr_data | input | 8 | New low byte from the ALU |
| jump_en | input | 1 | Jump or call strobe |
| jump_target | input | 11 | Opcode target field |
| ret_en | input | 1 | Return strobe |
| ret_addr | input | 13 | Address popped from the return stack |
| irq_vec_en | input | 1 | Interrupt entry strobe |
| page_wr_en | input | 1 | Page register write strobe |
| page_wr_data | input | 8 | Page register write data |
| pc_o | output | 13 | Current program counter |
| pc_low_rd | output | 8 | Low byte readback |
| page_rd | output | 8 | Page register readback |

## Verification
Every state element of this unit appears directly at a port. A wrong counter or page value therefore shows on pc_o or page_rd in the very cycle after the faulty load. A wrong choice between competing strobes also shows up one cycle later. The bench compares all three outputs with a behavioural model on every clock. The stimulus includes stacked strobes, page bits set above bit 4, wrap at 13'h1FFF, a page written in the same cycle as a load, and a reset in the middle of the run. A fault that corrupts the page register becomes visible on the address as soon as the next jump or low-byte write uses the page.

// File: rtl/pc_pager_pkg.sv
package pc_pager_pkg;

  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_INC  = 3'd1,
    SRC_LOW  = 3'd2,
    SRC_JUMP = 3'd3,
    SRC_RET  = 3'd4,
    SRC_VEC  = 3'd5
  } pc_src_e;

  typedef struct packed {
    logic inc;
    logic low_wr;
    logic jump;
    logic ret;
    logic vec;
  } pc_strobe_t;

endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_q,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAD_W = DATA_W - PAGE_W;

  logic [PAGE_W-1:0] page_d;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:PAGE_W];

  always_comb begin
    page_d = page_q;
    if (wr_en) page_d = wr_data[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  page_q <= '0;
    else if (wr_en)   page_q <= page_d;
  end

  assign rd_data = {{PAD_W{1'b0}}, page_q};

  assert_page_store_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en |=> page_q == $past(wr_data[PAGE_W-1:0]));

  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wr_en |=> $stable(page_q));

endmodule

// File: rtl/pc_src_arbiter.sv
module pc_src_arbiter
  import pc_pager_pkg::*;
(
  input  pc_strobe_t strobe,
  output pc_src_e    src
);

  always_comb begin
    if      (strobe.vec)    src = SRC_VEC;
    else if (strobe.ret)    src = SRC_RET;
    else if (strobe.jump)   src = SRC_JUMP;
    else if (strobe.low_wr) src = SRC_LOW;
    else if (strobe.inc)    src = SRC_INC;
    else                    src = SRC_HOLD;
  end

  always_comb begin
    if (strobe.vec) assert_vec_wins_R7: assert (src == SRC_VEC);
  end

endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_pager_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter int          LOW_W   = 8,
  parameter int          TGT_W   = 11,
  parameter int          PAGE_W  = 5,
  parameter logic [12:0] VEC     = 13'h004
) (
  input  pc_src_e           src,
  input  logic [PC_W-1:0]   pc_q,
  input  logic [PAGE_W-1:0] page_q,
  input  logic [LOW_W-1:0]  low_data,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [PC_W-1:0]   ret_addr,
  output logic [PC_W-1:0]   pc_d
);

  localparam int JPAGE_W = PC_W - TGT_W;
  localparam int LPAGE_W = PC_W - LOW_W;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_low;
  logic [PC_W-1:0] pc_jump;

  assign pc_inc  = pc_q + {{(PC_W-1){1'b0}}, 1'b1};
  assign pc_low  = {page_q[LPAGE_W-1:0], low_data};
  assign pc_jump = {page_q[PAGE_W-1 -: JPAGE_W], tgt};

  always_comb begin
    unique case (src)
      SRC_INC:  pc_d = pc_inc;
      SRC_LOW:  pc_d = pc_low;
      SRC_JUMP: pc_d = pc_jump;
      SRC_RET:  pc_d = ret_addr;
      SRC_VEC:  pc_d = VEC[PC_W-1:0];
      default:  pc_d = pc_q;
    endcase
  end

endmodule

// File: rtl/pc_pager.sv
module pc_pager
  import pc_pager_pkg::*;
#(
  parameter int          PC_W      = 13,
  parameter int          LOW_W     = 8,
  parameter int          TGT_W     = 11,
  parameter int          PAGE_W    = 5,
  parameter int          SYNC_STG  = 2,
  parameter logic [12:0] IRQ_VEC   = 13'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic              low_wr_en,
  input  logic [LOW_W-1:0]  low_wr_data,
  input  logic              jump_en,
  input  logic [TGT_W-1:0]  jump_target,
  input  logic              ret_en,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic              irq_vec_en,
  input  logic              page_wr_en,
  input  logic [LOW_W-1:0]  page_wr_data,
  output logic [PC_W-1:0]   pc_o,
  output logic [LOW_W-1:0]  pc_low_rd,
  output logic [LOW_W-1:0]  page_rd
);

  localparam int JPAGE_W = PC_W - TGT_W;

  logic              rst_core_n;
  logic [PAGE_W-1:0] page_q;
  pc_strobe_t        strobe;
  pc_src_e           src;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_d;
  logic              pc_ce;

  pc_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  pc_page_latch #(.PAGE_W(PAGE_W), .DATA_W(LOW_W)) u_page (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .wr_en      (page_wr_en),
    .wr_data    (page_wr_data),
    .page_q     (page_q),
    .rd_data    (page_rd)
  );

  assign strobe = '{inc: inc_en, low_wr: low_wr_en, jump: jump_en,
                    ret: ret_en, vec: irq_vec_en};

  pc_src_arbiter u_arb (
    .strobe (strobe),
    .src    (src)
  );

  pc_next_calc #(
    .PC_W(PC_W), .LOW_W(LOW_W), .TGT_W(TGT_W), .PAGE_W(PAGE_W), .VEC(IRQ_VEC)
  ) u_next (
    .src      (src),
    .pc_q     (pc_q),
    .page_q   (page_q),
    .low_data (low_wr_data),
    .tgt      (jump_target),
    .ret_addr (ret_addr),
    .pc_d     (pc_d)
  );

  assign pc_ce = (src != SRC_HOLD);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) pc_q <= '0;
    else if (pc_ce)  pc_q <= pc_d;
  end

  assign pc_o      = pc_q;
  assign pc_low_rd = pc_q[LOW_W-1:0];

  always @(posedge clk) begin
    if (!rst_core_n) assert_reset_clear_R1: assert (pc_q == '0 && page_q == '0);
  end

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_vec_en |=> pc_o == IRQ_VEC[PC_W-1:0]);

  assert_return_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ret_en && !irq_vec_en) |=> pc_o == $past(ret_addr));

  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (jump_en && !ret_en && !irq_vec_en)
      |=> pc_o == {$past(page_q[PAGE_W-1 -: JPAGE_W]), $past(jump_target)});

  assert_low_write_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (low_wr_en && !jump_en && !ret_en && !irq_vec_en)
      |=> pc_o[LOW_W-1:0] == $past(low_wr_data));

  assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (inc_en && !low_wr_en && !jump_en && !ret_en && !irq_vec_en)
      |=> pc_o == $past(pc_o) + 1'b1);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!inc_en && !low_wr_en && !jump_en && !ret_en && !irq_vec_en) |=> $stable(pc_o));

endmodule

// File: tb/pc_pager_tb_top.sv
module pc_pager_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inc_en, low_wr_en, jump_en, ret_en, irq_vec_en, page_wr_en;
  logic [7:0]  low_wr_data, page_wr_data;
  logic [10:0] jump_target;
  logic [12:0] ret_addr;
  logic [12:0] pc_o;
  logic [7:0]  pc_low_rd, page_rd;

  always #10 clk = ~clk;

  pc_pager dut_i (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .low_wr_en(low_wr_en),
    .low_wr_data(low_wr_data), .jump_en(jump_en), .jump_target(jump_target),
    .ret_en(ret_en), .ret_addr(ret_addr), .irq_vec_en(irq_vec_en),
    .page_wr_en(page_wr_en), .page_wr_data(page_wr_data),
    .pc_o(pc_o), .pc_low_rd(pc_low_rd), .page_rd(page_rd)
  );

  int    n_vec  = 0;
  int    n_fail = 0;
  int    m_pc   = 0;
  int    m_page = 0;
  int    m_cnt  = 0;
  string cur_tag = "R1";

  task automatic compare();
    n_vec++;
    if (pc_o !== 13'(m_pc)) begin
      n_fail++;
      $display("FAIL %s pc_o got %h exp %h", cur_tag, pc_o, 13'(m_pc));
    end
    if (pc_low_rd !== 8'(m_pc)) begin
      n_fail++;
      $display("FAIL R10 pc_low_rd got %h exp %h", pc_low_rd, 8'(m_pc));
    end
    if (page_rd !== 8'(m_page)) begin
      n_fail++;
      $display("FAIL R8/R9 page_rd got %h exp %h", page_rd, 8'(m_page));
    end
  endtask

  // one clock: check the previous result, drive new inputs, advance the model
  task automatic cycle(input bit rs, input bit inc, input bit lw, input int ld,
                       input bit jp, input int tg, input bit rt, input int ra,
                       input bit iv, input bit pw, input int pd, input string tag);
    int nxt;
    @(negedge clk);
    compare();
    rst_n = rs; inc_en = inc; low_wr_en = lw; low_wr_data = 8'(ld);
    jump_en = jp; jump_target = 11'(tg); ret_en = rt; ret_addr = 13'(ra);
    irq_vec_en = iv; page_wr_en = pw; page_wr_data = 8'(pd);
    cur_tag = tag;
    if (!rs) begin
      m_pc = 0; m_page = 0; m_cnt = 0; cur_tag = "R1";
    end else if (m_cnt < 2) begin
      m_cnt++; cur_tag = "R1";
    end else begin
      if (iv)      nxt = 4;
      else if (rt) nxt = ra & 'h1FFF;
      else if (jp) nxt = ((m_page >> 3) << 11) | (tg & 'h7FF);
      else if (lw) nxt = (m_page << 8) | (ld & 'hFF);
      else if (inc) nxt = (m_pc + 1) % 8192;
      else nxt = m_pc;
      if (pw) m_page = pd & 'h1F;
      m_pc = nxt;
    end
  endtask

  task automatic idle(input string tag);
    cycle(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  function automatic string tag_of(bit inc, bit lw, bit jp, bit rt, bit iv);
    if (iv) return "R6";
    if (rt) return "R5";
    if (jp) return "R4";
    if (lw) return "R3";
    if (inc) return "R2";
    return "R7";
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; inc_en = 0; low_wr_en = 0; jump_en = 0; ret_en = 0;
    irq_vec_en = 0; page_wr_en = 0; low_wr_data = 0; page_wr_data = 0;
    jump_target = 0; ret_addr = 0;
    // R1: strobes during reset and the two release edges are ignored
    cycle(0, 1, 1, 'h55, 1, 'h123, 0, 0, 0, 1, 'h1F, "R1");
    cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 'h0A, "R1");
    cycle(1, 1, 0, 0, 0, 0, 1, 'h777, 0, 0, 0, "R1");
    idle("R1");
    // R2: increment
    cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R8: page write with high bits set, load in same cycle uses old page
    cycle(1, 0, 1, 'hFF, 0, 0, 0, 0, 0, 1, 'hFF, "R8");
    idle("R8");
    // R2: wrap 1FFF -> 0
    cycle(1, 0, 1, 'hFF, 0, 0, 0, 0, 0, 0, 0, "R3");
    cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R4: jump keeps only page bits 4:3
    cycle(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 'h15, "R8");
    cycle(1, 0, 0, 0, 1, 'h6A5, 0, 0, 0, 0, 0, "R4");
    // R3: computed offset wraps in the 256-word block
    cycle(1, 0, 1, 'hF0, 0, 0, 0, 0, 0, 0, 0, "R3");
    cycle(1, 0, 1, ('hF0 + 'h20) & 'hFF, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R5, R6, R7: stacked strobes
    cycle(1, 1, 1, 'h11, 1, 'h222, 1, 'h1ABC, 0, 0, 0, "R5");
    cycle(1, 1, 1, 'h11, 1, 'h222, 1, 'h0333, 1, 0, 0, "R6");
    cycle(1, 1, 1, 'h3C, 1, 'h0F0, 0, 0, 0, 0, 0, "R7");
    cycle(1, 1, 1, 'h3C, 0, 0, 0, 0, 0, 0, 0, "R7");
    idle("R7");
    // R9: returns and vectors do not touch the page
    cycle(1, 0, 0, 0, 0, 0, 1, 'h1FFF, 0, 0, 0, "R9");
    cycle(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
    idle("R9");
    for (int i = 0; i < 3000; i++) begin
      bit inc = ($urandom % 2) == 0;
      bit lw  = ($urandom % 4) == 0;
      bit jp  = ($urandom % 5) == 0;
      bit rt  = ($urandom % 6) == 0;
      bit iv  = ($urandom % 16) == 0;
      bit pw  = ($urandom % 5) == 0;
      bit rs  = !(i >= 1500 && i < 1503);
      cycle(rs, inc, lw, int'($urandom % 256), jp, int'($urandom % 2048),
            rt, int'($urandom % 8192), iv, pw, int'($urandom % 256),
            tag_of(inc, lw, jp, rt, iv));
    end
    idle("R7");
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule